// File: doc/BRIEF.md
# Software write-protect sequence detector

This block sits beside the write engine of a byte-wide EEPROM and watches every byte write handed to it (a 15-bit address and an 8-bit data value, qualified by a strobe). It recognises two command sequences written to two magic addresses. A three-write arming prefix switches protection on and authorises the data bytes that follow it. A six-write release sequence switches protection off. The block keeps the resulting persistent protect flag. For every write it tells the engine whether that byte may be loaded into the page buffer for programming.

The write engine owns the page-load window timer. It sends `win_done` for one cycle when the load window of the current burst closes and internal programming starts. A pending protect change takes effect on that pulse, even when no data byte followed the command. While protection is on, a burst that does not open with the arming prefix gets no commit for any of its bytes, so the engine runs its programming timer without changing the array. Command bytes are never committed.

The sequencer states are:
- IDLE: waiting for the first write of a burst.
- ARM1 and ARM2: the first and second matched command writes.
- REL3, REL4 and REL5: the third, fourth and fifth matched writes of the release sequence.
- LOAD_ON: an arming prefix has completed.
- LOAD_OFF: a release sequence has completed.
- PLAIN: an unprefixed burst while unprotected.
- BLOCK: an unprefixed burst while protected.

The transitions are:
- IDLE goes to ARM1 on 0xAA at 0x5555.
- ARM1 goes to ARM2 on 0x55 at 0x2AAA.
- ARM2 goes to LOAD_ON on 0xA0 at 0x5555, or to REL3 on 0x80 at 0x5555.
- REL3 goes to REL4 on 0xAA at 0x5555.
- REL4 goes to REL5 on 0x55 at 0x2AAA.
- REL5 goes to LOAD_OFF on 0x20 at 0x5555.
- Any other write in IDLE or in a partial state goes to PLAIN or BLOCK, depending on the flag.
- `win_done` sends every state back to IDLE.

Top module: `wp_seq_guard`

## Requirements
- R1: After reset `prot_on` is 0 and `commit_ok` is 0 while `wr_stb` is low.
- R2: While unprotected, every write of a burst whose first write is not 0xAA at 0x5555 gets `commit_ok`=1 in its own strobe cycle.
- R3: The arming prefix is 0xAA at 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555. Its writes get `commit_ok`=0 and the data writes after it get `commit_ok`=1. `prot_on` stays unchanged until it becomes 1 in the cycle after `win_done`.
- R4: An arming prefix followed by no data write still sets `prot_on` in the cycle after `win_done`.
- R5: While protected, every write of a burst that does not open with the arming prefix gets `commit_ok`=0, and `prot_on` stays 1 after its `win_done`.
- R6: While protected, data writes after the arming prefix get `commit_ok`=1 and `prot_on` stays 1.
- R7: The release sequence is 0xAA at 0x5555, 0x55 at 0x2AAA, 0x80 at 0x5555, 0xAA at 0x5555, 0x55 at 0x2AAA, then 0x20 at 0x5555. Its writes get `commit_ok`=0 and the data writes after it get `commit_ok`=1. `prot_on` becomes 0 in the cycle after `win_done`, with or without data.
- R8: A write that does not continue a partial sequence is handled as data. It gets `commit_ok` equal to the inverse of `prot_on`, and so do the rest of its burst.
- R9: `commit_ok` is 1 only while `wr_stb` is 1, and `prot_on` changes only in the cycle after a `win_done`.
- R10: A `win_done` pulse during a partial sequence drops the sequence without changing `prot_on`. A following 0xA0 at 0x5555 is then handled as data.
- R11: After `win_done` the next write starts a new burst, so an arming prefix is recognised again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the protect flag |
| wr_stb | input | 1 | One byte write this cycle |
| wr_addr | input | 15 | Byte address of the write |
| wr_data | input | 8 | Byte value of the write |
| win_done | input | 1 | One-cycle pulse: load window closed, programming starts |
| prot_on | output | 1 | Persistent software protect flag |
| commit_ok | output | 1 | The byte written this cycle may be loaded for programming |

## Verification
The hardest situation to reach is a partial command sequence broken part way, either by a stray write or by a window closing. Such a break must leave no residue, and the case that shows this is a later 0xA0 at 0x5555 that must then be handled as data. Plain random addresses almost never hit the magic pairs. The random stimulus therefore draws most writes from a pool of the five command pairs and cuts sequences short at random lengths, and directed cases add a release sequence with no data and a window closing after two matched writes.

// File: rtl/wp_pkg.sv
package wp_pkg;

    typedef enum logic [2:0] {
        CK_OTHER = 3'd0,
        CK_AA    = 3'd1,
        CK_55    = 3'd2,
        CK_A0    = 3'd3,
        CK_80    = 3'd4,
        CK_20    = 3'd5
    } cmd_kind_t;

    typedef enum logic [3:0] {
        ST_IDLE     = 4'd0,
        ST_ARM1     = 4'd1,
        ST_ARM2     = 4'd2,
        ST_REL3     = 4'd3,
        ST_REL4     = 4'd4,
        ST_REL5     = 4'd5,
        ST_LOAD_ON  = 4'd6,
        ST_LOAD_OFF = 4'd7,
        ST_PLAIN    = 4'd8,
        ST_BLOCK    = 4'd9
    } seq_state_t;

endpackage

// File: rtl/wp_cmd_decode.sv
module wp_cmd_decode
    import wp_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] MAGIC_HI = 15'h5555,
    parameter logic [ADDR_W-1:0] MAGIC_LO = 15'h2AAA,
    parameter logic [DATA_W-1:0] KEY_LEAD = 8'hAA,
    parameter logic [DATA_W-1:0] KEY_PAIR = 8'h55,
    parameter logic [DATA_W-1:0] KEY_ARM  = 8'hA0,
    parameter logic [DATA_W-1:0] KEY_PRE  = 8'h80,
    parameter logic [DATA_W-1:0] KEY_REL  = 8'h20
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output cmd_kind_t         kind_o
);

    logic at_hi;
    logic at_lo;

    assign at_hi = (addr_i == MAGIC_HI);
    assign at_lo = (addr_i == MAGIC_LO);

    always_comb begin
        kind_o = CK_OTHER;
        if (at_hi && data_i == KEY_LEAD)      kind_o = CK_AA;
        else if (at_lo && data_i == KEY_PAIR) kind_o = CK_55;
        else if (at_hi && data_i == KEY_ARM)  kind_o = CK_A0;
        else if (at_hi && data_i == KEY_PRE)  kind_o = CK_80;
        else if (at_hi && data_i == KEY_REL)  kind_o = CK_20;
    end

endmodule

// File: rtl/wp_seq_fsm.sv
module wp_seq_fsm
    import wp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_stb_i,
    input  cmd_kind_t kind_i,
    input  logic      win_done_i,
    input  logic      prot_i,
    output logic      commit_o,
    output logic      set_prot_o,
    output logic      clr_prot_o
);

    seq_state_t state_q;
    seq_state_t state_d;
    seq_state_t brk_state;
    logic       step_ok;

    assign brk_state = prot_i ? ST_BLOCK : ST_PLAIN;

    // does this write continue the sequence in progress
    always_comb begin
        step_ok = 1'b0;
        unique case (state_q)
            ST_IDLE:     step_ok = (kind_i == CK_AA);
            ST_ARM1:     step_ok = (kind_i == CK_55);
            ST_ARM2:     step_ok = (kind_i == CK_A0) || (kind_i == CK_80);
            ST_REL3:     step_ok = (kind_i == CK_AA);
            ST_REL4:     step_ok = (kind_i == CK_55);
            ST_REL5:     step_ok = (kind_i == CK_20);
            ST_LOAD_ON, ST_LOAD_OFF, ST_PLAIN, ST_BLOCK: step_ok = 1'b0;
            default:     step_ok = 1'b0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        if (win_done_i) begin
            state_d = ST_IDLE;
        end else if (wr_stb_i) begin
            unique case (state_q)
                ST_IDLE: state_d = step_ok ? ST_ARM1 : brk_state;
                ST_ARM1: state_d = step_ok ? ST_ARM2 : brk_state;
                ST_ARM2: begin
                    if (kind_i == CK_A0)      state_d = ST_LOAD_ON;
                    else if (kind_i == CK_80) state_d = ST_REL3;
                    else                      state_d = brk_state;
                end
                ST_REL3: state_d = step_ok ? ST_REL4 : brk_state;
                ST_REL4: state_d = step_ok ? ST_REL5 : brk_state;
                ST_REL5: state_d = step_ok ? ST_LOAD_OFF : brk_state;
                ST_LOAD_ON, ST_LOAD_OFF, ST_PLAIN, ST_BLOCK: state_d = state_q;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        commit_o   = 1'b0;
        set_prot_o = win_done_i && (state_q == ST_LOAD_ON);
        clr_prot_o = win_done_i && (state_q == ST_LOAD_OFF);
        if (wr_stb_i) begin
            unique case (state_q)
                ST_IDLE, ST_ARM1, ST_ARM2, ST_REL3, ST_REL4, ST_REL5:
                    commit_o = !step_ok && !prot_i;
                ST_LOAD_ON, ST_LOAD_OFF, ST_PLAIN:
                    commit_o = 1'b1;
                ST_BLOCK:
                    commit_o = 1'b0;
                default:
                    commit_o = 1'b0;
            endcase
        end
    end

    // R9: a byte is committed only in a strobe cycle
    a_r9_commit_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> wr_stb_i);

    // R5: a blocked burst never commits
    a_r5_block_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BLOCK) |-> !commit_o);

    // R8: while protected, a burst start commits nothing
    a_r8_protected_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && prot_i) |-> !commit_o);

    // R11: a closed window always returns the sequencer to idle
    a_r11_window_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        win_done_i |=> (state_q == ST_IDLE));

endmodule

// File: rtl/wp_prot_reg.sv
module wp_prot_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic prot_o
);

    logic prot_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     prot_q <= 1'b0;
        else if (set_i) prot_q <= 1'b1;
        else if (clr_i) prot_q <= 1'b0;
    end

    assign prot_o = prot_q;

    // R9: the flag moves only after an end-of-window update request
    a_r9_change_on_window: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(prot_q) |-> $past(set_i || clr_i));

    // R3: a rise of the flag follows an arming request
    a_r3_rise_from_arm: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_q) |-> $past(set_i));

    // R7: a fall of the flag follows a release request
    a_r7_fall_from_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_q) |-> $past(clr_i));

endmodule

// File: rtl/wp_seq_guard.sv
module wp_seq_guard
    import wp_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              win_done,
    output logic              prot_on,
    output logic              commit_ok
);

    cmd_kind_t kind;
    logic      set_prot;
    logic      clr_prot;

    wp_cmd_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_decode (
        .addr_i (wr_addr),
        .data_i (wr_data),
        .kind_o (kind)
    );

    wp_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb_i   (wr_stb),
        .kind_i     (kind),
        .win_done_i (win_done),
        .prot_i     (prot_on),
        .commit_o   (commit_ok),
        .set_prot_o (set_prot),
        .clr_prot_o (clr_prot)
    );

    wp_prot_reg u_prot (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_prot),
        .clr_i  (clr_prot),
        .prot_o (prot_on)
    );

endmodule

// File: tb/wp_seq_guard_bench.sv
`timescale 1ns/1ps
module wp_seq_guard_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic [14:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        win_done = 1'b0;
    logic        prot_on;
    logic        commit_ok;

    int checks = 0;
    int errors = 0;

    // bench model: 0 idle, 1..5 partial, 6 arm load, 7 release load, 8 plain, 9 block
    int m_st = 0;
    int m_prot = 0;

    always #2.5 clk = ~clk;

    wp_seq_guard u_wp_seq_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .win_done  (win_done),
        .prot_on   (prot_on),
        .commit_ok (commit_ok)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // 1 AA@5555, 2 55@2AAA, 3 A0@5555, 4 80@5555, 5 20@5555, 0 other
    function automatic int kind_of(input logic [14:0] a, input logic [7:0] d);
        if (a == 15'h5555 && d == 8'hAA) return 1;
        if (a == 15'h2AAA && d == 8'h55) return 2;
        if (a == 15'h5555 && d == 8'hA0) return 3;
        if (a == 15'h5555 && d == 8'h80) return 4;
        if (a == 15'h5555 && d == 8'h20) return 5;
        return 0;
    endfunction

    function automatic int exp_next(input int st, input int k, input int p);
        int brk = p ? 9 : 8;
        case (st)
            0: return (k == 1) ? 1 : brk;
            1: return (k == 2) ? 2 : brk;
            2: return (k == 3) ? 6 : ((k == 4) ? 3 : brk);
            3: return (k == 1) ? 4 : brk;
            4: return (k == 2) ? 5 : brk;
            5: return (k == 5) ? 7 : brk;
            default: return st;
        endcase
    endfunction

    function automatic int exp_commit(input int st, input int k, input int p);
        if (st == 9) return 0;
        if (st >= 6) return 1;
        if (exp_next(st, k, p) < 8) return 0;   // command byte
        return p ? 0 : 1;
    endfunction

    task automatic do_write(input string req, input logic [14:0] a, input logic [7:0] d);
        int k = kind_of(a, d);
        @(negedge clk);
        wr_stb = 1'b1; wr_addr = a; wr_data = d;
        #1;
        check(req, int'(commit_ok), exp_commit(m_st, k, m_prot));
        @(posedge clk);
        m_st = exp_next(m_st, k, m_prot);
        #1;
        wr_stb = 1'b0;
    endtask

    task automatic end_window(input string req);
        @(negedge clk);
        win_done = 1'b1;
        @(posedge clk);
        if (m_st == 6) m_prot = 1;
        if (m_st == 7) m_prot = 0;
        m_st = 0;
        #1;
        win_done = 1'b0;
        check(req, int'(prot_on), m_prot);
    endtask

    task automatic arm_prefix(input string req);
        do_write(req, 15'h5555, 8'hAA);
        do_write(req, 15'h2AAA, 8'h55);
        do_write(req, 15'h5555, 8'hA0);
    endtask

    task automatic release_seq(input string req);
        do_write(req, 15'h5555, 8'hAA);
        do_write(req, 15'h2AAA, 8'h55);
        do_write(req, 15'h5555, 8'h80);
        do_write(req, 15'h5555, 8'hAA);
        do_write(req, 15'h2AAA, 8'h55);
        do_write(req, 15'h5555, 8'h20);
    endtask

    task automatic pool_write(input string req);
        int r = $urandom % 6;
        case (r)
            0: do_write(req, 15'h5555, 8'hAA);
            1: do_write(req, 15'h2AAA, 8'h55);
            2: do_write(req, 15'h5555, 8'hA0);
            3: do_write(req, 15'h5555, 8'h80);
            4: do_write(req, 15'h5555, 8'h20);
            default: do_write(req, 15'($urandom), 8'($urandom));
        endcase
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(posedge clk);
        #1;
        check("R1 prot after reset", int'(prot_on), 0);
        check("R1 commit idle", int'(commit_ok), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 plain unprotected burst
        do_write("R2", 15'h0010, 8'h11);
        do_write("R2", 15'h0011, 8'h22);
        do_write("R2", 15'h5555, 8'hAA);
        end_window("R2 prot stays");

        // R3 arm with data, flag held until window end
        arm_prefix("R3");
        do_write("R3", 15'h0100, 8'h33);
        do_write("R3", 15'h0101, 8'h44);
        check("R3 prot before window", int'(prot_on), 0);
        end_window("R3 prot set");

        // R5 protected burst without prefix
        do_write("R5", 15'h0200, 8'h01);
        do_write("R5", 15'h0201, 8'h02);
        do_write("R5", 15'h0202, 8'h03);
        end_window("R5 prot held");

        // R6 protected burst with prefix
        arm_prefix("R6");
        do_write("R6", 15'h0300, 8'h55);
        end_window("R6 prot held");

        // R7 release with no data
        release_seq("R7");
        check("R7 prot before window", int'(prot_on), 1);
        end_window("R7 prot cleared");

        // R8 broken sequence while unprotected
        do_write("R8", 15'h5555, 8'hAA);
        do_write("R8", 15'h0100, 8'h12);
        do_write("R8", 15'h0101, 8'h13);
        end_window("R8 prot");

        // R10 window closes mid-sequence, stale A0 is data
        do_write("R10", 15'h5555, 8'hAA);
        do_write("R10", 15'h2AAA, 8'h55);
        end_window("R10 prot unchanged");
        do_write("R10 stale A0 is data", 15'h5555, 8'hA0);
        end_window("R10 prot after");

        // R4 arm with no data
        arm_prefix("R4");
        end_window("R4 prot set");

        // R8 broken sequence while protected
        do_write("R8", 15'h5555, 8'hAA);
        do_write("R8", 15'h2AAA, 8'h56);
        do_write("R8", 15'h0005, 8'h77);
        end_window("R8 prot held");

        // R11 new burst recognises prefix after window
        arm_prefix("R11");
        do_write("R11", 15'h0400, 8'h99);
        end_window("R11");

        // R7 release with data
        release_seq("R7");
        do_write("R7", 15'h0500, 8'hCC);
        end_window("R7 prot cleared");

        // random phase
        for (int i = 0; i < 300; i++) begin
            int sel = $urandom % 6;
            int n = $urandom % 4;
            case (sel)
                0: arm_prefix("R3");
                1: release_seq("R7");
                2: begin
                    do_write("R8", 15'h5555, 8'hAA);
                    if (n > 1) do_write("R8", 15'h2AAA, 8'h55);
                end
                default: ;
            endcase
            for (int j = 0; j < n + 1; j++) pool_write("R8");
            @(negedge clk);
            #1;
            check("R9 commit without strobe", int'(commit_ok), 0);
            end_window("R9");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule